// File: doc/BRIEF.md
# Half-Integer Clock Divider with Integer Taps

This block divides an incoming clock by a programmable modulus. It can also divide by that modulus minus one half. The core is a modulo-N counter whose clock passes through an exclusive-OR stage with an enable. The other operand of the exclusive-OR is a toggle flip-flop, and the counter's terminal-count pulse flips that flip-flop. With the exclusive-OR enabled, each toggle inverts the counter's clock phase, so one half period is dropped per counter cycle. The terminal-count output then rises once every N-0.5 input periods, and the toggle output is a square wave of 50% duty at twice that ratio.

With the exclusive-OR disabled, the counter runs straight off the input clock and the block is an integer divider. It offers a narrow one-count pulse and a near-half duty output at the modulus. It also offers the binary counter taps and the toggle output, which give divide-by-2 up to divide-by-32 at full range. The modulus is set by the terminal count value: the modulus equals that value plus one, for values from 1 to 15.

Top module: `halfint_clk_div`

## Requirements
- R1: While `clr_i` is high, `tap_o`, `frac_o`, `sq_o` and `duty_o` are 0 and `sq_n_o` is 1, with no clock needed.
- R2: With `cnt_en_i` high, `tap_o` advances by one on each counter clock edge from 0 up to `last_i`, then returns to 0. In integer mode the first input clock rise after clear gives 1.
- R3: `frac_o` is high exactly while `tap_o` equals `last_i`, which lasts one counter clock period.
- R4: `sq_o` changes state at every rise of `frac_o`, and `sq_n_o` is always its complement.
- R5: With `xor_en_i`=1 and `last_i`=8, `frac_o` rises every 8.5 input periods and stays high for half an input period.
- R6: With `xor_en_i`=1 and `last_i`=8, `sq_o` has a period of 17 input periods and is high for 8.5 of them.
- R7: With `xor_en_i`=0 and `last_i`=8, `frac_o` has a period of 9 input periods and is high for one of them.
- R8: With `xor_en_i`=0, `duty_o` is high for floor(N/2) of every N counts, where N=`last_i`+1. At `last_i`=8 it is high 4 of 9 periods.
- R9: With `xor_en_i`=0 and `last_i`=15, `tap_o[k]` has a period of 2^(k+1) input periods at 50% duty, and `sq_o` has a period of 32 input periods at 50% duty.
- R10: While `cnt_en_i` is low, `tap_o`, `frac_o`, `sq_o` and `duty_o` hold their values. Counting resumes from the held value.
- R11: With `xor_en_i`=1, the `frac_o` period is `last_i`+0.5 input periods for other moduli too. At `last_i`=4 the period is 4.5 input periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Incoming clock to divide |
| clr_i | input | 1 | Active-high asynchronous clear of counter and toggle |
| cnt_en_i | input | 1 | Counter advance enable |
| xor_en_i | input | 1 | 1: half-integer mode, 0: integer mode |
| last_i | input | CNT_W | Terminal count value; modulus is this plus one |
| frac_o | output | 1 | Terminal-count pulse, the fractional-ratio output |
| sq_o | output | 1 | Toggle output, square wave at twice the ratio |
| sq_n_o | output | 1 | Inverted toggle output |
| duty_o | output | 1 | Near-half duty output at the modulus |
| tap_o | output | CNT_W | Counter state, binary ratio taps |

## Verification
Edge-to-edge times of each output are measured in nanoseconds against a 10 ns input clock. Half-integer mode is tried at two moduli, 9 and 5. A result of 85 ns or 45 ns can only come from the dropped half period, while 90 ns or 50 ns would show that the exclusive-OR path is not working. Integer mode at modulus 9 tells the single-count pulse apart from the 4:5 near-half output. Full-range integer mode separates each binary tap and the toggle stage by their doubling periods. A stepped count trace and an enable-low window show the wrap point and the freezing of every output.

// File: rtl/hdiv_pkg.sv
package hdiv_pkg;
  // Default counter width: moduli up to 16
  localparam int unsigned HDIV_CNT_W = 4;
endpackage

// File: rtl/hdiv_xor_gate.sv
module hdiv_xor_gate (
  input  logic a_i,
  input  logic b_i,
  input  logic en_i,
  output logic y_o
);
  // Enabled: a xor b. Disabled: b passes through unchanged.
  assign y_o = en_i ? (a_i ^ b_i) : b_i;
endmodule

// File: rtl/hdiv_mod_counter.sv
module hdiv_mod_counter #(
  parameter int unsigned W = hdiv_pkg::HDIV_CNT_W
) (
  input  logic         clk_i,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] cnt_o,
  output logic         tc_o,
  output logic         half_o
);
  localparam int unsigned TW = W + 1;

  logic [W-1:0]  cnt_q, cnt_nxt;
  logic          tc_q, half_q;
  logic [TW-1:0] thr;

  // First count of the high part of the near-half output: ceil((last+1)/2)
  assign thr     = ({1'b0, last_i} + TW'(2)) >> 1;
  assign cnt_nxt = (cnt_q >= last_i) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or posedge clr_i) begin
    if (clr_i) begin
      cnt_q  <= '0;
      tc_q   <= 1'b0;
      half_q <= 1'b0;
    end else if (en_i) begin
      cnt_q  <= cnt_nxt;
      tc_q   <= (cnt_nxt == last_i);
      half_q <= ({1'b0, cnt_nxt} >= thr);
    end
  end

  assign cnt_o  = cnt_q;
  assign tc_o   = tc_q;
  assign half_o = half_q;
endmodule

// File: rtl/hdiv_toggle.sv
module hdiv_toggle (
  input  logic clk_i,
  input  logic clr_i,
  output logic q_o,
  output logic qn_o
);
  logic q;

  // D is fed from the inverted output
  always_ff @(posedge clk_i or posedge clr_i) begin
    if (clr_i) q <= 1'b0;
    else       q <= ~q;
  end

  assign q_o  = q;
  assign qn_o = ~q;
endmodule

// File: rtl/halfint_clk_div.sv
module halfint_clk_div #(
  parameter int unsigned CNT_W = hdiv_pkg::HDIV_CNT_W
) (
  input  logic             clk_i,
  input  logic             clr_i,
  input  logic             cnt_en_i,
  input  logic             xor_en_i,
  input  logic [CNT_W-1:0] last_i,
  output logic             frac_o,
  output logic             sq_o,
  output logic             sq_n_o,
  output logic             duty_o,
  output logic [CNT_W-1:0] tap_o
);
  logic cnt_clk;
  logic tc;
  logic tq, tqn;

  hdiv_xor_gate u_gate (
    .a_i  (tq),
    .b_i  (clk_i),
    .en_i (xor_en_i),
    .y_o  (cnt_clk)
  );

  hdiv_mod_counter #(.W(CNT_W)) u_cnt (
    .clk_i  (cnt_clk),
    .clr_i  (clr_i),
    .en_i   (cnt_en_i),
    .last_i (last_i),
    .cnt_o  (tap_o),
    .tc_o   (tc),
    .half_o (duty_o)
  );

  hdiv_toggle u_tog (
    .clk_i (tc),
    .clr_i (clr_i),
    .q_o   (tq),
    .qn_o  (tqn)
  );

  assign frac_o = tc;
  assign sq_o   = tq;
  assign sq_n_o = tqn;
endmodule

// File: rtl/hdiv_checker.sv
module hdiv_checker #(
  parameter int unsigned W = hdiv_pkg::HDIV_CNT_W
) (
  input logic         cnt_clk,
  input logic         clr_i,
  input logic         cnt_en_i,
  input logic [W-1:0] last_i,
  input logic [W-1:0] tap_o,
  input logic         frac_o,
  input logic         sq_o,
  input logic         duty_o
);
  AST_COUNT_STEP: assert property (@(posedge cnt_clk) disable iff (clr_i)
    (cnt_en_i && tap_o < last_i) |=> (tap_o == $past(tap_o) + 1'b1)); // R2

  AST_COUNT_WRAP: assert property (@(posedge cnt_clk) disable iff (clr_i)
    (cnt_en_i && tap_o == last_i) |=> (tap_o == '0)); // R2

  AST_FRAC_SINGLE: assert property (@(posedge cnt_clk) disable iff (clr_i)
    (cnt_en_i && frac_o && last_i != '0) |=> !frac_o); // R3

  AST_SQ_TOGGLE: assert property (@(posedge cnt_clk) disable iff (clr_i)
    (cnt_en_i && last_i != '0 && tap_o == last_i - 1'b1) |=> (sq_o != $past(sq_o))); // R4

  AST_HOLD: assert property (@(posedge cnt_clk) disable iff (clr_i)
    !cnt_en_i |=> ($stable(tap_o) && $stable(frac_o) && $stable(sq_o) && $stable(duty_o))); // R10
endmodule

bind halfint_clk_div hdiv_checker #(.W(CNT_W)) u_chk (
  .cnt_clk  (cnt_clk),
  .clr_i    (clr_i),
  .cnt_en_i (cnt_en_i),
  .last_i   (last_i),
  .tap_o    (tap_o),
  .frac_o   (frac_o),
  .sq_o     (sq_o),
  .duty_o   (duty_o)
);

// File: tb/halfint_clk_div_test.sv
`timescale 1ns/1ps

module hdiv_edge_meter (
  input  logic   sig,
  input  logic   rst,
  output int     per,
  output int     hi,
  output longint rise_t,
  output longint edge_t
);
  bit seen = 0;
  initial begin per = 0; hi = 0; rise_t = 0; edge_t = -1; end
  always @(posedge rst) begin seen = 0; per = 0; hi = 0; end
  always @(posedge sig) begin
    if (seen) per = int'(longint'($time) - rise_t);
    rise_t = longint'($time);
    seen = 1;
  end
  always @(negedge sig) if (seen) hi = int'(longint'($time) - rise_t);
  always @(posedge sig or negedge sig) edge_t = longint'($time);
endmodule

module halfint_clk_div_test;
  logic       clk = 0, clr = 1, en = 1, xen = 0;
  logic [3:0] last = 4'd8;
  logic       frac, sq, sqn, duty;
  logic [3:0] tap;
  int n_tot = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  halfint_clk_div uut (
    .clk_i(clk), .clr_i(clr), .cnt_en_i(en), .xor_en_i(xen), .last_i(last),
    .frac_o(frac), .sq_o(sq), .sq_n_o(sqn), .duty_o(duty), .tap_o(tap)
  );

  int fp, fh, sp, sh, dp, dh;
  int tp0, th0, tp1, th1, tp2, th2, tp3, th3;
  longint fr, fe, sr, se, dr, de, x0, y0, x1, y1, x2, y2, x3, y3;
  hdiv_edge_meter m_f (.sig(frac),   .rst(clr), .per(fp),  .hi(fh),  .rise_t(fr), .edge_t(fe));
  hdiv_edge_meter m_s (.sig(sq),     .rst(clr), .per(sp),  .hi(sh),  .rise_t(sr), .edge_t(se));
  hdiv_edge_meter m_d (.sig(duty),   .rst(clr), .per(dp),  .hi(dh),  .rise_t(dr), .edge_t(de));
  hdiv_edge_meter m_0 (.sig(tap[0]), .rst(clr), .per(tp0), .hi(th0), .rise_t(x0), .edge_t(y0));
  hdiv_edge_meter m_1 (.sig(tap[1]), .rst(clr), .per(tp1), .hi(th1), .rise_t(x1), .edge_t(y1));
  hdiv_edge_meter m_2 (.sig(tap[2]), .rst(clr), .per(tp2), .hi(th2), .rise_t(x2), .edge_t(y2));
  hdiv_edge_meter m_3 (.sig(tap[3]), .rst(clr), .per(tp3), .hi(th3), .rise_t(x3), .edge_t(y3));

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_tot++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_mode(input logic x, input logic [3:0] l, input int settle_ns);
    @(negedge clk);
    clr = 1; xen = x; last = l; en = 1;
    @(negedge clk);
    clr = 0;
    #(settle_ns);
  endtask

  task automatic t_reset();
    clr = 1;
    #3;
    chk("R1", "tap", tap, 0);
    chk("R1", "frac", frac, 0);
    chk("R1", "sq", sq, 0);
    chk("R1", "sq_n", sqn, 1);
    chk("R1", "duty", duty, 0);
  endtask

  task automatic t_count_trace();
    set_mode(1'b0, 4'd4, 0);
    chk("R2", "tap after clear", tap, 0);
    for (int i = 1; i <= 12; i++) begin
      @(posedge clk); #1;
      chk("R2", "tap step", tap, i % 5);
      chk("R3", "frac at terminal", frac, (i % 5 == 4) ? 1 : 0);
    end
  endtask

  task automatic t_half_9();
    set_mode(1'b1, 4'd8, 800);
    chk("R5", "frac period ns", fp, 85);
    chk("R5", "frac high ns", fh, 5);
    chk("R6", "sq period ns", sp, 170);
    chk("R6", "sq high ns", sh, 85);
    chk("R4", "sq edge at frac rise", se, fr);
    chk("R4", "sq_n complement", sqn, !sq);
  endtask

  task automatic t_half_5();
    set_mode(1'b1, 4'd4, 500);
    chk("R11", "frac period ns", fp, 45);
    chk("R11", "sq period ns", sp, 90);
  endtask

  task automatic t_int_9();
    set_mode(1'b0, 4'd8, 500);
    chk("R7", "frac period ns", fp, 90);
    chk("R7", "frac high ns", fh, 10);
    chk("R8", "duty period ns", dp, 90);
    chk("R8", "duty high ns", dh, 40);
  endtask

  task automatic t_binary();
    set_mode(1'b0, 4'd15, 1000);
    chk("R9", "tap0 period", tp0, 20);  chk("R9", "tap0 high", th0, 10);
    chk("R9", "tap1 period", tp1, 40);  chk("R9", "tap1 high", th1, 20);
    chk("R9", "tap2 period", tp2, 80);  chk("R9", "tap2 high", th2, 40);
    chk("R9", "tap3 period", tp3, 160); chk("R9", "tap3 high", th3, 80);
    chk("R9", "sq period", sp, 320);    chk("R9", "sq high", sh, 160);
  endtask

  task automatic t_hold();
    logic [3:0] t0;
    logic f0, s0, d0;
    set_mode(1'b0, 4'd8, 73);
    @(negedge clk);
    en = 0;
    #2;
    t0 = tap; f0 = frac; s0 = sq; d0 = duty;
    #200;
    chk("R10", "tap held", tap, t0);
    chk("R10", "frac held", frac, f0);
    chk("R10", "sq held", sq, s0);
    chk("R10", "duty held", duty, d0);
    @(negedge clk);
    en = 1;
    #20;
    chk("R10", "resume count", tap, (t0 + 2) % 9);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_tot++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_count_trace();
    t_half_9();
    t_half_5();
    t_int_9();
    t_binary();
    t_hold();
    done = 1;
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end
endmodule